// File: doc/BRIEF.md
# PWM Output Fault Protection Unit

This block sits between a timer's waveform outputs and the pin drivers. It watches an external fault input and a debug-break request. When a qualified fault occurs while protection is armed, it raises a per-pin direction-override mask. The pad logic uses this mask to clear the direction bits of the enabled channels, which tri-states those outputs.

Recovery is always aligned to the timer's UPDATE strobe. In cycle-by-cycle mode the outputs come back on the first UPDATE after the fault has gone away. In latched mode software must also have cleared the fault flag before that UPDATE.

Software sees the block through an 8-bit control register and an 8-bit status register. The control register holds the action field, the restart mode and the debug-break ignore bit. The status register holds the fault flag and two dead-time buffer-valid indications, which are supplied as inputs.

Top module: `pwm_fault_guard`

## Requirements
- R1: After synchronous reset, both registers read 0x00, `fault_active` is 0 and `dir_override` is all zero.
- R2: The control register keeps writes to bit 4 (debug ignore), bit 2 (restart mode) and bits 1:0 (action). Bits 7:5 and 3 always read 0, whatever was written to them.
- R3: The status register reads as follows: bit 2 is the fault flag, bit 1 mirrors `hs_buf_valid`, bit 0 mirrors `ls_buf_valid`, and bits 7:3 read 0.
- R4: With action 11, a fault seen at a clock edge sets `fault_active` and the status fault flag from that edge on.
- R5: Action values 00, 01 and 10 leave protection off: a fault sets neither `fault_active` nor the flag (default parameter). If the action field leaves 11, `fault_active` clears at the next edge.
- R6: When control bit 4 is 0, `dbg_break` acts as a fault. When bit 4 is 1, `dbg_break` is ignored.
- R7: In cycle-by-cycle mode (bit 2 = 1), `fault_active` clears at the first edge where `update_stb` is 1 and no fault is seen. No software action is needed, and the state is held on edges without `update_stb`.
- R8: In latched mode (bit 2 = 0), `fault_active` clears only at an `update_stb` edge where no fault is seen and the fault flag already reads 0.
- R9: Writing 1 to status bit 2 clears the flag, and writing 0 there has no effect. A fault seen in the same cycle as a clear leaves the flag set.
- R10: A fault present at an `update_stb` edge keeps `fault_active` set.
- R11: `dir_override[i]` equals `chan_en[i]` while `fault_active` is 1, and is 0 otherwise. It follows `chan_en` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| stat_we | input | 1 | Status register write strobe |
| stat_wdata | input | 8 | Status register write data (bit 2 = clear flag) |
| fault_in | input | 1 | External fault condition, active high |
| dbg_break | input | 1 | Debug break request |
| update_stb | input | 1 | Timer UPDATE strobe |
| chan_en | input | NPIN | Pins belonging to enabled dead-time channels |
| hs_buf_valid | input | 1 | High-side dead-time buffer valid |
| ls_buf_valid | input | 1 | Low-side dead-time buffer valid |
| dir_override | output | NPIN | Per-pin direction clear request |
| fault_active | output | 1 | Outputs held in fault state |
| ctrl_rdata | output | 8 | Control register read data |
| stat_rdata | output | 8 | Status register read data |

## Verification
Two pairs of events can fall on the same edge, and each pair is driven on purpose. The first pair is a software flag clear and a fresh qualified fault. The bench expects the flag to remain 1 and checks this through the status register. The second pair is an UPDATE strobe and a still-present fault. The bench expects `fault_active` to stay set, and then to clear one edge later once the fault drops while the strobe is still high.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    localparam int REG_W         = 8;
    localparam int CTRL_DBG_BIT  = 4;
    localparam int CTRL_MODE_BIT = 2;
    localparam int STAT_FLAG_BIT = 2;
    localparam int STAT_HS_BIT   = 1;
    localparam int STAT_LS_BIT   = 0;

    typedef enum logic [1:0] {
        ACT_OFF      = 2'b00,
        ACT_RSV_A    = 2'b01,
        ACT_RSV_B    = 2'b10,
        ACT_TRISTATE = 2'b11
    } fault_act_e;

    typedef enum logic {
        RESTART_LATCHED = 1'b0,
        RESTART_CYCLE   = 1'b1
    } restart_e;

    typedef struct packed {
        logic       dbg_ignore;
        restart_e   mode;
        fault_act_e act;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.dbg_ignore = w[CTRL_DBG_BIT];
        c.mode       = restart_e'(w[CTRL_MODE_BIT]);
        c.act        = fault_act_e'(w[1:0]);
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [REG_W-1:0] w;
        w                = '0;
        w[CTRL_DBG_BIT]  = c.dbg_ignore;
        w[CTRL_MODE_BIT] = c.mode;
        w[1:0]           = c.act;
        return w;
    endfunction

    function automatic logic prot_armed(input ctrl_t c);
        return c.act == ACT_TRISTATE;
    endfunction

endpackage

// File: rtl/pfg_regs.sv
module pfg_regs
    import pfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  logic [REG_W-1:0] ctrl_wdata,
    input  logic             stat_we,
    input  logic [REG_W-1:0] stat_wdata,
    input  logic             flag_set,
    input  logic             hs_valid,
    input  logic             ls_valid,
    output ctrl_t            ctrl,
    output logic             flag,
    output logic [REG_W-1:0] ctrl_rdata,
    output logic [REG_W-1:0] stat_rdata
);

    ctrl_t ctrl_q;
    logic  flag_q;
    logic  flag_clr;

    assign flag_clr = stat_we && stat_wdata[STAT_FLAG_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_from_word(ctrl_wdata);
        end
    end

    // a detection in the same cycle takes priority over a software clear
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (flag_set) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        stat_rdata                = '0;
        stat_rdata[STAT_FLAG_BIT] = flag_q;
        stat_rdata[STAT_HS_BIT]   = hs_valid;
        stat_rdata[STAT_LS_BIT]   = ls_valid;
    end

    assign ctrl       = ctrl_q;
    assign flag       = flag_q;
    assign ctrl_rdata = ctrl_to_word(ctrl_q);

endmodule

// File: rtl/pfg_qual.sv
module pfg_qual
    import pfg_pkg::*;
#(
    parameter bit RECORD_WHEN_OFF = 1'b0
) (
    input  ctrl_t ctrl,
    input  logic  fault_in,
    input  logic  dbg_break,
    output logic  fault_seen,
    output logic  trip,
    output logic  flag_set
);

    logic dbg_fault;

    assign dbg_fault  = dbg_break && !ctrl.dbg_ignore;
    assign fault_seen = fault_in || dbg_fault;
    assign trip       = fault_seen && prot_armed(ctrl);

    generate
        if (RECORD_WHEN_OFF) begin : g_rec_always
            assign flag_set = fault_seen;
        end else begin : g_rec_armed
            assign flag_set = trip;
        end
    endgenerate

endmodule

// File: rtl/pfg_state.sv
module pfg_state
    import pfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  logic  trip,
    input  logic  fault_seen,
    input  logic  flag,
    input  logic  update_stb,
    output logic  active
);

    logic active_q;
    logic exit_ok;

    always_comb begin
        unique case (ctrl.mode)
            RESTART_CYCLE:   exit_ok = !fault_seen;
            RESTART_LATCHED: exit_ok = !fault_seen && !flag;
            default:         exit_ok = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
        end else if (!prot_armed(ctrl)) begin
            active_q <= 1'b0;
        end else if (trip) begin
            active_q <= 1'b1;
        end else if (active_q && update_stb && exit_ok) begin
            active_q <= 1'b0;
        end
    end

    assign active = active_q;

endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
    import pfg_pkg::*;
#(
    parameter int NPIN            = 8,
    parameter bit RECORD_WHEN_OFF = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  logic [REG_W-1:0] ctrl_wdata,
    input  logic             stat_we,
    input  logic [REG_W-1:0] stat_wdata,
    input  logic             fault_in,
    input  logic             dbg_break,
    input  logic             update_stb,
    input  logic [NPIN-1:0]  chan_en,
    input  logic             hs_buf_valid,
    input  logic             ls_buf_valid,
    output logic [NPIN-1:0]  dir_override,
    output logic             fault_active,
    output logic [REG_W-1:0] ctrl_rdata,
    output logic [REG_W-1:0] stat_rdata
);

    ctrl_t ctrl;
    logic  flag;
    logic  fault_seen;
    logic  trip;
    logic  flag_set;
    logic  active;

    pfg_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .stat_we    (stat_we),
        .stat_wdata (stat_wdata),
        .flag_set   (flag_set),
        .hs_valid   (hs_buf_valid),
        .ls_valid   (ls_buf_valid),
        .ctrl       (ctrl),
        .flag       (flag),
        .ctrl_rdata (ctrl_rdata),
        .stat_rdata (stat_rdata)
    );

    pfg_qual #(
        .RECORD_WHEN_OFF (RECORD_WHEN_OFF)
    ) u_qual (
        .ctrl       (ctrl),
        .fault_in   (fault_in),
        .dbg_break  (dbg_break),
        .fault_seen (fault_seen),
        .trip       (trip),
        .flag_set   (flag_set)
    );

    pfg_state u_state (
        .clk        (clk),
        .rst        (rst),
        .ctrl       (ctrl),
        .trip       (trip),
        .fault_seen (fault_seen),
        .flag       (flag),
        .update_stb (update_stb),
        .active     (active)
    );

    generate
        for (genvar p = 0; p < NPIN; p++) begin : g_pin
            assign dir_override[p] = active && chan_en[p];
        end
    endgenerate

    assign fault_active = active;

endmodule

// File: rtl/pfg_checker.sv
module pfg_checker
    import pfg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ctrl_we,
    input logic             stat_we,
    input logic [REG_W-1:0] stat_wdata,
    input logic             fault_in,
    input logic             dbg_break,
    input logic             update_stb,
    input logic [REG_W-1:0] ctrl_rdata,
    input logic [REG_W-1:0] stat_rdata,
    input logic             fault_active
);

    logic armed;
    assign armed = (ctrl_rdata[1:0] == 2'b11);

    AST_FAULT_ENTERS: assert property (@(posedge clk) disable iff (rst)
        armed && fault_in |=> fault_active && stat_rdata[STAT_FLAG_BIT]); // R4

    AST_OFF_NO_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        !armed |=> !fault_active); // R5

    AST_DBG_TRIPS: assert property (@(posedge clk) disable iff (rst)
        armed && !ctrl_rdata[CTRL_DBG_BIT] && dbg_break |=> fault_active); // R6

    AST_HOLD_NO_UPDATE: assert property (@(posedge clk) disable iff (rst)
        fault_active && armed && !ctrl_we && !update_stb |=> fault_active); // R7

    AST_LATCH_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        fault_active && armed && !ctrl_we && !ctrl_rdata[CTRL_MODE_BIT]
        && stat_rdata[STAT_FLAG_BIT] |=> fault_active); // R8

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        armed && fault_in && stat_we && stat_wdata[STAT_FLAG_BIT]
        |=> stat_rdata[STAT_FLAG_BIT]); // R9

    AST_FAULT_AT_UPDATE: assert property (@(posedge clk) disable iff (rst)
        fault_active && armed && fault_in && update_stb |=> fault_active); // R10

endmodule

bind pwm_fault_guard pfg_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .ctrl_we      (ctrl_we),
    .stat_we      (stat_we),
    .stat_wdata   (stat_wdata),
    .fault_in     (fault_in),
    .dbg_break    (dbg_break),
    .update_stb   (update_stb),
    .ctrl_rdata   (ctrl_rdata),
    .stat_rdata   (stat_rdata),
    .fault_active (fault_active)
);

// File: tb/pwm_fault_guard_tb_top.sv
module pwm_fault_guard_tb_top;

    localparam int NPIN = 8;

    logic            clk = 1'b0;
    logic            rst;
    logic            ctrl_we;
    logic [7:0]      ctrl_wdata;
    logic            stat_we;
    logic [7:0]      stat_wdata;
    logic            fault_in;
    logic            dbg_break;
    logic            update_stb;
    logic [NPIN-1:0] chan_en;
    logic            hs_buf_valid;
    logic            ls_buf_valid;
    logic [NPIN-1:0] dir_override;
    logic            fault_active;
    logic [7:0]      ctrl_rdata;
    logic [7:0]      stat_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pwm_fault_guard #(.NPIN(NPIN)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .ctrl_we      (ctrl_we),
        .ctrl_wdata   (ctrl_wdata),
        .stat_we      (stat_we),
        .stat_wdata   (stat_wdata),
        .fault_in     (fault_in),
        .dbg_break    (dbg_break),
        .update_stb   (update_stb),
        .chan_en      (chan_en),
        .hs_buf_valid (hs_buf_valid),
        .ls_buf_valid (ls_buf_valid),
        .dir_override (dir_override),
        .fault_active (fault_active),
        .ctrl_rdata   (ctrl_rdata),
        .stat_rdata   (stat_rdata)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        ctrl_we = 1'b1; ctrl_wdata = v;
        tick();
        ctrl_we = 1'b0; ctrl_wdata = '0;
    endtask

    task automatic wr_stat(input logic [7:0] v);
        stat_we = 1'b1; stat_wdata = v;
        tick();
        stat_we = 1'b0; stat_wdata = '0;
    endtask

    // bring the block back to idle: protection off, flag cleared
    task automatic quiesce();
        fault_in = 0; dbg_break = 0; update_stb = 0;
        wr_ctrl(8'h00);
        wr_stat(8'h04);
    endtask

    task automatic t_reset();
        check("R1 ctrl", ctrl_rdata, 8'h00);
        check("R1 stat", stat_rdata, 8'h00);
        check("R1 active", fault_active, 1'b0);
        check("R1 override", dir_override, '0);
    endtask

    task automatic t_ctrl_fields();
        wr_ctrl(8'hFF);
        check("R2 all ones", ctrl_rdata, 8'h17);
        wr_ctrl(8'hE8);
        check("R2 reserved only", ctrl_rdata, 8'h00);
        wr_ctrl(8'h12);
        check("R2 mixed", ctrl_rdata, 8'h12);
        wr_ctrl(8'h00);
    endtask

    task automatic t_status_mirror();
        hs_buf_valid = 1; ls_buf_valid = 0; #1;
        check("R3 hs", stat_rdata, 8'h02);
        hs_buf_valid = 0; ls_buf_valid = 1; #1;
        check("R3 ls", stat_rdata, 8'h01);
        wr_stat(8'hFB);
        check("R3 write other bits", stat_rdata, 8'h01);
        ls_buf_valid = 0;
    endtask

    task automatic t_cycle_mode();
        wr_ctrl(8'h07);
        fault_in = 1; tick();
        check("R4 active", fault_active, 1'b1);
        check("R4 flag", stat_rdata[2], 1'b1);
        fault_in = 0; tick(); tick();
        check("R7 hold without update", fault_active, 1'b1);
        update_stb = 1; tick();
        update_stb = 0;
        check("R7 self exit", fault_active, 1'b0);
        check("R7 flag kept", stat_rdata[2], 1'b1);
        quiesce();
    endtask

    task automatic t_latched_mode();
        wr_ctrl(8'h03);
        fault_in = 1; tick();
        fault_in = 0;
        check("R8 entered", fault_active, 1'b1);
        update_stb = 1; tick();
        update_stb = 0;
        check("R8 blocked by flag", fault_active, 1'b1);
        wr_stat(8'h04);
        check("R8 flag cleared", stat_rdata[2], 1'b0);
        check("R8 still active", fault_active, 1'b1);
        update_stb = 1; tick();
        update_stb = 0;
        check("R8 exit", fault_active, 1'b0);
        quiesce();
    endtask

    task automatic t_update_with_fault();
        wr_ctrl(8'h07);
        fault_in = 1; tick();
        update_stb = 1; tick();
        check("R10 held at update", fault_active, 1'b1);
        fault_in = 0; tick();
        update_stb = 0;
        check("R10 exit after", fault_active, 1'b0);
        quiesce();
    endtask

    task automatic t_flag_clear();
        wr_ctrl(8'h07);
        fault_in = 1;
        wr_stat(8'h04);
        check("R9 set beats clear", stat_rdata[2], 1'b1);
        fault_in = 0;
        wr_stat(8'h00);
        check("R9 write zero", stat_rdata[2], 1'b1);
        wr_stat(8'h04);
        check("R9 write one", stat_rdata[2], 1'b0);
        quiesce();
    endtask

    task automatic t_debug();
        wr_ctrl(8'h07);
        dbg_break = 1; tick();
        dbg_break = 0;
        check("R6 debug trips", fault_active, 1'b1);
        quiesce();
        wr_ctrl(8'h17);
        dbg_break = 1; tick(); tick();
        dbg_break = 0;
        check("R6 debug ignored", fault_active, 1'b0);
        check("R6 no flag", stat_rdata[2], 1'b0);
        quiesce();
    endtask

    task automatic t_disabled();
        for (int a = 0; a < 3; a++) begin
            wr_ctrl(8'h04 | 8'(a));
            fault_in = 1; tick(); tick();
            fault_in = 0;
            check("R5 no active", fault_active, 1'b0);
            check("R5 no flag", stat_rdata[2], 1'b0);
            check("R5 no override", dir_override, '0);
        end
        wr_ctrl(8'h07);
        fault_in = 1; tick();
        wr_ctrl(8'h04);
        tick();
        check("R5 disarm clears", fault_active, 1'b0);
        quiesce();
    endtask

    task automatic t_override();
        wr_ctrl(8'h07);
        chan_en = 8'hA5;
        fault_in = 1; tick();
        check("R11 mask", dir_override, 8'hA5);
        chan_en = 8'h3C; #1;
        check("R11 follows", dir_override, 8'h3C);
        fault_in = 0; update_stb = 1; tick();
        update_stb = 0;
        check("R11 released", dir_override, 8'h00);
        quiesce();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst = 1; ctrl_we = 0; ctrl_wdata = 0; stat_we = 0; stat_wdata = 0;
        fault_in = 0; dbg_break = 0; update_stb = 0; chan_en = 8'hFF;
        hs_buf_valid = 0; ls_buf_valid = 0;
        tick(); tick();
        rst = 0; tick();
        t_reset();
        t_ctrl_fields();
        t_status_mirror();
        t_cycle_mode();
        t_latched_mode();
        t_update_with_fault();
        t_flag_clear();
        t_debug();
        t_disabled();
        t_override();
        finish_run();
    end

endmodule